// File: doc/BRIEF.md
# Dual Data Pointer and Memory Access Router

This block is a special-function-register slice for a small 8-bit microcontroller. It keeps two 16-bit data pointers and a control register that chooses which of them is active. The core uses the active pointer as the address of its pointer-based data accesses, and the block sends each such access either to an on-chip EEPROM port or to the external data memory bus, as a control bit selects.

Byte writes to the EEPROM go through only when a write-enable bit is set. Once a write starts, the block holds a busy state until the EEPROM reports completion, and it blocks further EEPROM-bound accesses until then. One bit of the control register does two jobs. Written as 1, it sends a one-cycle kick pulse to a watchdog counter outside the block. Read back, it shows the EEPROM ready/busy flag. The core reads and writes the pointers and the control register over an 8-bit address, 8-bit data register bus, and it can advance the active pointer with an increment strobe.

Top module: `dptr_mem_route`

## Requirements
- R1: After a synchronous reset, all four pointer bytes read 00H. The control register at 96H reads 02H, which is the stored value 00H with the ready flag showing 1. The kick output is low.
- R2: Bank 0 is at register address 82H (low byte) and 83H (high byte). Bank 1 is at 84H (low) and 85H (high). A byte written at one of these addresses reads back from the same address in the next cycle.
- R3: Control bit 2 chooses the active pointer: 0 selects bank 0 and 1 selects bank 1. The memory address presented on both memory ports is the active pointer.
- R4: A high pulse on the increment strobe adds one to the active bank only, effective at the next clock. The low byte carries into the high byte, and FFFFH wraps to 0000H.
- R5: While control bit 3 is 1, a memory request drives the EEPROM port and leaves the external request low. While bit 3 is 0, the request goes to the external port only. Both are combinational in the same cycle.
- R6: With bits 3 and 4 both 1, a memory write asserts the EEPROM request and write strobe in the same cycle. From the next cycle on, control bit 1 reads 0. It reads 1 again from the cycle after the EEPROM done input is sampled high.
- R7: With bit 4 at 0, a memory write bound for the EEPROM is dropped. No EEPROM request is raised and bit 1 stays 1.
- R8: While a write is in progress, EEPROM-bound reads and writes raise no EEPROM request.
- R9: Writing 96H with bit 1 set drives the kick output high for exactly the following cycle. Bit 1 is not stored: on read it always shows the ready flag. Bits 7 to 5 and bit 0 read as 0.
- R10: If the increment strobe falls in the same cycle as a register write to a byte of the active bank, the write wins and that bank is not incremented. A write to the other bank does not stop the increment.
- R11: The memory read data output passes the EEPROM read data when bit 3 is 1 and the external read data when bit 3 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | Register bus address |
| sfr_wr | input | 1 | Register bus write strobe |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_rdata | output | 8 | Register bus read data (combinational) |
| dptr_inc | input | 1 | Increment the active pointer |
| mem_req | input | 1 | Pointer-based memory access request |
| mem_we | input | 1 | Access is a write |
| mem_wdata | input | 8 | Write data from core |
| mem_rdata | output | 8 | Read data to core |
| ee_req | output | 1 | EEPROM access request |
| ee_we | output | 1 | EEPROM write strobe |
| ee_addr | output | 16 | EEPROM address |
| ee_wdata | output | 8 | EEPROM write data |
| ee_rdata | input | 8 | EEPROM read data |
| ee_done | input | 1 | EEPROM programming complete |
| xm_req | output | 1 | External memory request |
| xm_we | output | 1 | External memory write strobe |
| xm_addr | output | 16 | External memory address |
| xm_wdata | output | 8 | External memory write data |
| xm_rdata | input | 8 | External memory read data |
| wdt_kick | output | 1 | One-cycle watchdog kick pulse |

## Verification
The increment strobe and a register write to a pointer byte can land in the same clock, and the two update paths then compete for one bank. The bench raises the strobe in the same cycle as a write to the low byte of the active bank, and again as a write to the inactive bank. It then reads all four bytes back over the register bus. The first case must show only the written byte with no increment. The second must show both the write and the increment.

// File: rtl/dptr_pkg.sv
package dptr_pkg;

    localparam int DATA_W    = 8;
    localparam int SFR_AW    = 8;
    localparam int PTR_W     = 16;
    localparam int NUM_BANKS = 2;
    localparam int BYTES     = PTR_W / DATA_W;
    localparam int SEL_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    localparam logic [SFR_AW-1:0] DPTR_BASE = 8'h82;
    localparam logic [SFR_AW-1:0] CTRL_ADDR = 8'h96;

    localparam int BIT_MWE  = 4;
    localparam int BIT_MEN  = 3;
    localparam int BIT_SEL  = 2;
    localparam int BIT_KICK = 1;

    typedef struct packed {
        logic mwe;
        logic men;
        logic sel;
    } ctrl_t;

    typedef enum logic {EE_IDLE = 1'b0, EE_BUSY = 1'b1} ee_state_t;

    function automatic ctrl_t ctrl_unpack(input logic [DATA_W-1:0] d);
        ctrl_t c;
        c.mwe = d[BIT_MWE];
        c.men = d[BIT_MEN];
        c.sel = d[BIT_SEL];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_pack(input ctrl_t c, input logic rdy);
        logic [DATA_W-1:0] d;
        d           = '0;
        d[BIT_MWE]  = c.mwe;
        d[BIT_MEN]  = c.men;
        d[BIT_SEL]  = c.sel;
        d[BIT_KICK] = rdy;
        return d;
    endfunction

endpackage

// File: rtl/dptr_bank_file.sv
module dptr_bank_file
    import dptr_pkg::*;
#(
    parameter int PW  = PTR_W,
    parameter int DW  = DATA_W,
    parameter int AW  = SFR_AW,
    parameter int NB  = NUM_BANKS,
    parameter int SW  = SEL_W,
    parameter logic [AW-1:0] BASE = DPTR_BASE
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [SW-1:0]          sel,
    input  logic                   inc,
    input  logic                   wr,
    input  logic [AW-1:0]          waddr,
    input  logic [DW-1:0]          wdata,
    output logic [NB-1:0][PW-1:0]  ptrs
);
    localparam int NBYTE = PW / DW;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [NBYTE-1:0] hit;
        logic [PW-1:0]    ptr_q;

        for (genvar j = 0; j < NBYTE; j++) begin : g_byte
            localparam logic [AW-1:0] BYTE_ADDR = AW'(int'(BASE) + b * NBYTE + j);
            assign hit[j] = wr && (waddr == BYTE_ADDR);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q <= '0;
            end else if (|hit) begin
                for (int j = 0; j < NBYTE; j++) begin
                    if (hit[j]) ptr_q[j*DW +: DW] <= wdata;
                end
            end else if (inc && (sel == SW'(b))) begin
                ptr_q <= ptr_q + 1'b1;
            end
        end

        assign ptrs[b] = ptr_q;
    end
endmodule

// File: rtl/ee_write_seq.sv
module ee_write_seq
    import dptr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic done,
    output logic busy
);
    ee_state_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= EE_IDLE;
        end else begin
            case (state_q)
                EE_IDLE: if (start) state_q <= EE_BUSY;
                EE_BUSY: if (done)  state_q <= EE_IDLE;
                default:            state_q <= EE_IDLE;
            endcase
        end
    end

    assign busy = (state_q == EE_BUSY);
endmodule

// File: rtl/access_router.sv
module access_router
    import dptr_pkg::*;
#(
    parameter int PW = PTR_W,
    parameter int DW = DATA_W
) (
    input  logic          mem_req,
    input  logic          mem_we,
    input  logic [DW-1:0] mem_wdata,
    input  logic [PW-1:0] addr,
    input  logic          men,
    input  logic          mwe,
    input  logic          busy,
    input  logic [DW-1:0] ee_rdata,
    input  logic [DW-1:0] xm_rdata,
    output logic          ee_req,
    output logic          ee_we,
    output logic [PW-1:0] ee_addr,
    output logic [DW-1:0] ee_wdata,
    output logic          xm_req,
    output logic          xm_we,
    output logic [PW-1:0] xm_addr,
    output logic [DW-1:0] xm_wdata,
    output logic [DW-1:0] mem_rdata,
    output logic          wr_start
);
    logic ee_go;

    always_comb begin
        ee_go     = mem_req && men && !busy && (!mem_we || mwe);
        ee_req    = ee_go;
        ee_we     = ee_go && mem_we;
        wr_start  = ee_go && mem_we;
        xm_req    = mem_req && !men;
        xm_we     = xm_req && mem_we;
        ee_addr   = addr;
        xm_addr   = addr;
        ee_wdata  = mem_wdata;
        xm_wdata  = mem_wdata;
        mem_rdata = men ? ee_rdata : xm_rdata;
    end
endmodule

// File: rtl/dptr_mem_route.sv
module dptr_mem_route
    import dptr_pkg::*;
#(
    parameter int PW = PTR_W,
    parameter int DW = DATA_W,
    parameter int AW = SFR_AW,
    parameter int NB = NUM_BANKS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] sfr_addr,
    input  logic          sfr_wr,
    input  logic [DW-1:0] sfr_wdata,
    output logic [DW-1:0] sfr_rdata,
    input  logic          dptr_inc,
    input  logic          mem_req,
    input  logic          mem_we,
    input  logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] mem_rdata,
    output logic          ee_req,
    output logic          ee_we,
    output logic [PW-1:0] ee_addr,
    output logic [DW-1:0] ee_wdata,
    input  logic [DW-1:0] ee_rdata,
    input  logic          ee_done,
    output logic          xm_req,
    output logic          xm_we,
    output logic [PW-1:0] xm_addr,
    output logic [DW-1:0] xm_wdata,
    input  logic [DW-1:0] xm_rdata,
    output logic          wdt_kick
);
    localparam int NBYTE = PW / DW;
    localparam int SW    = (NB > 1) ? $clog2(NB) : 1;

    ctrl_t                ctrl_q;
    logic                 kick_q;
    logic                 busy;
    logic                 wr_start;
    logic [NB-1:0][PW-1:0] ptrs;
    logic [SW-1:0]        sel;
    logic [PW-1:0]        act_ptr;
    logic                 ctrl_wr;

    assign ctrl_wr = sfr_wr && (sfr_addr == CTRL_ADDR);
    assign sel     = SW'(ctrl_q.sel);
    assign act_ptr = ptrs[sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            kick_q <= 1'b0;
        end else begin
            kick_q <= ctrl_wr && sfr_wdata[BIT_KICK];
            if (ctrl_wr) ctrl_q <= ctrl_unpack(sfr_wdata);
        end
    end

    assign wdt_kick = kick_q;

    dptr_bank_file #(.PW(PW), .DW(DW), .AW(AW), .NB(NB), .SW(SW), .BASE(DPTR_BASE)) u_banks (
        .clk   (clk),
        .rst   (rst),
        .sel   (sel),
        .inc   (dptr_inc),
        .wr    (sfr_wr),
        .waddr (sfr_addr),
        .wdata (sfr_wdata),
        .ptrs  (ptrs)
    );

    ee_write_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (wr_start),
        .done  (ee_done),
        .busy  (busy)
    );

    access_router #(.PW(PW), .DW(DW)) u_route (
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .addr      (act_ptr),
        .men       (ctrl_q.men),
        .mwe       (ctrl_q.mwe),
        .busy      (busy),
        .ee_rdata  (ee_rdata),
        .xm_rdata  (xm_rdata),
        .ee_req    (ee_req),
        .ee_we     (ee_we),
        .ee_addr   (ee_addr),
        .ee_wdata  (ee_wdata),
        .xm_req    (xm_req),
        .xm_we     (xm_we),
        .xm_addr   (xm_addr),
        .xm_wdata  (xm_wdata),
        .mem_rdata (mem_rdata),
        .wr_start  (wr_start)
    );

    always_comb begin
        sfr_rdata = '0;
        if (sfr_addr == CTRL_ADDR) sfr_rdata = ctrl_pack(ctrl_q, !busy);
        for (int b = 0; b < NB; b++) begin
            for (int j = 0; j < NBYTE; j++) begin
                if (sfr_addr == AW'(int'(DPTR_BASE) + b * NBYTE + j))
                    sfr_rdata = ptrs[b][j*DW +: DW];
            end
        end
    end
endmodule

// File: rtl/dptr_mem_route_chk.sv
module dptr_mem_route_chk
    import dptr_pkg::*;
#(
    parameter int PW = PTR_W,
    parameter int DW = DATA_W,
    parameter int AW = SFR_AW
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] sfr_addr,
    input logic          sfr_wr,
    input logic [DW-1:0] sfr_wdata,
    input logic          dptr_inc,
    input logic          ee_req,
    input logic          ee_we,
    input logic          xm_req,
    input logic          wdt_kick,
    input logic          ee_done,
    input logic          busy,
    input logic [PW-1:0] act_ptr
);
    // R5: never both ports at once
    a_r5_one_port: assert property (@(posedge clk) disable iff (rst)
        !(ee_req && xm_req));

    // R6: an accepted EEPROM write makes the block busy next cycle
    a_r6_busy_after_write: assert property (@(posedge clk) disable iff (rst)
        (ee_req && ee_we) |=> busy);

    // R6: busy stays until done is seen
    a_r6_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && !ee_done) |=> busy);

    // R8: no EEPROM request while busy
    a_r8_blocked: assert property (@(posedge clk) disable iff (rst)
        busy |-> !ee_req);

    // R9: kick only follows a control write with bit 1 set
    a_r9_kick_source: assert property (@(posedge clk) disable iff (rst)
        wdt_kick |-> $past(sfr_wr && (sfr_addr == CTRL_ADDR) && sfr_wdata[BIT_KICK]));

    // R4: increment without a register write advances the active pointer by one
    a_r4_increment: assert property (@(posedge clk) disable iff (rst)
        (dptr_inc && !sfr_wr) |=> (act_ptr == PW'($past(act_ptr) + 1'b1)));
endmodule

bind dptr_mem_route dptr_mem_route_chk #(.PW(PW), .DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sfr_addr  (sfr_addr),
    .sfr_wr    (sfr_wr),
    .sfr_wdata (sfr_wdata),
    .dptr_inc  (dptr_inc),
    .ee_req    (ee_req),
    .ee_we     (ee_we),
    .xm_req    (xm_req),
    .wdt_kick  (wdt_kick),
    .ee_done   (ee_done),
    .busy      (busy),
    .act_ptr   (act_ptr)
);

// File: tb/sim_dptr_mem_route.sv
module sim_dptr_mem_route;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  sfr_addr;
    logic        sfr_wr;
    logic [7:0]  sfr_wdata;
    logic [7:0]  sfr_rdata;
    logic        dptr_inc;
    logic        mem_req;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        ee_req;
    logic        ee_we;
    logic [15:0] ee_addr;
    logic [7:0]  ee_wdata;
    logic [7:0]  ee_rdata;
    logic        ee_done;
    logic        xm_req;
    logic        xm_we;
    logic [15:0] xm_addr;
    logic [7:0]  xm_wdata;
    logic [7:0]  xm_rdata;
    logic        wdt_kick;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dptr_mem_route u0 (
        .clk(clk), .rst(rst),
        .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
        .dptr_inc(dptr_inc),
        .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
        .ee_rdata(ee_rdata), .ee_done(ee_done),
        .xm_req(xm_req), .xm_we(xm_we), .xm_addr(xm_addr), .xm_wdata(xm_wdata),
        .xm_rdata(xm_rdata), .wdt_kick(wdt_kick)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // advance one clock: inputs are always changed just after a falling edge
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        sfr_addr = a;
        #1;
        d = sfr_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        cyc();
        sfr_wr = 1'b0;
    endtask

    task automatic rd_ptr(input int bank, output logic [15:0] p);
        logic [7:0] lo, hi;
        rd(8'(8'h82 + 2 * bank), lo);
        rd(8'(8'h83 + 2 * bank), hi);
        p = {hi, lo};
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int a = 8'h82; a <= 8'h85; a++) begin
            rd(8'(a), d);
            chk("R1 pointer byte after reset", {8'h0, d}, 16'h0000);
        end
        rd(8'h96, d);
        chk("R1 control after reset", {8'h0, d}, 16'h0002);
        chk("R1 kick after reset", {15'h0, wdt_kick}, 16'h0000);
    endtask

    task automatic t_ptr_rw();
        logic [15:0] p;
        wr(8'h82, 8'h34); wr(8'h83, 8'h12);
        wr(8'h84, 8'hCD); wr(8'h85, 8'hAB);
        rd_ptr(0, p); chk("R2 bank0 readback", p, 16'h1234);
        rd_ptr(1, p); chk("R2 bank1 readback", p, 16'hABCD);
    endtask

    task automatic t_select_ext();
        wr(8'h96, 8'h00);
        xm_rdata = 8'h3C; ee_rdata = 8'hC3;
        mem_req = 1'b1; mem_we = 1'b0;
        #1;
        chk("R3 bank0 address", xm_addr, 16'h1234);
        chk("R5 external request", {14'h0, xm_req, ee_req}, 16'h0002);
        chk("R11 external read data", {8'h0, mem_rdata}, 16'h003C);
        mem_req = 1'b0;
        wr(8'h96, 8'h04);
        mem_req = 1'b1;
        #1;
        chk("R3 bank1 address", xm_addr, 16'hABCD);
        mem_req = 1'b0;
    endtask

    task automatic t_inc();
        logic [15:0] p;
        wr(8'h84, 8'hFF); wr(8'h85, 8'h00);
        dptr_inc = 1'b1; cyc(); dptr_inc = 1'b0;
        rd_ptr(1, p); chk("R4 carry into high byte", p, 16'h0100);
        rd_ptr(0, p); chk("R4 inactive bank unchanged", p, 16'h1234);
        wr(8'h84, 8'hFF); wr(8'h85, 8'hFF);
        dptr_inc = 1'b1; cyc(); dptr_inc = 1'b0;
        rd_ptr(1, p); chk("R4 wrap to zero", p, 16'h0000);
    endtask

    task automatic t_route_ee();
        wr(8'h96, 8'h08);
        ee_rdata = 8'h5A;
        mem_req = 1'b1; mem_we = 1'b0;
        #1;
        chk("R5 eeprom request", {14'h0, xm_req, ee_req}, 16'h0001);
        chk("R3 eeprom address bank0", ee_addr, 16'h1234);
        chk("R11 eeprom read data", {8'h0, mem_rdata}, 16'h005A);
        mem_req = 1'b0;
    endtask

    task automatic t_write_ignored();
        logic [7:0] d;
        wr(8'h96, 8'h08);
        mem_req = 1'b1; mem_we = 1'b1; mem_wdata = 8'h77;
        #1;
        chk("R7 no eeprom request", {14'h0, ee_req, ee_we}, 16'h0000);
        cyc();
        mem_req = 1'b0; mem_we = 1'b0;
        rd(8'h96, d);
        chk("R7 still ready", {8'h0, d}, 16'h000A);
    endtask

    task automatic t_ee_write();
        logic [7:0] d;
        wr(8'h96, 8'h18);
        mem_req = 1'b1; mem_we = 1'b1; mem_wdata = 8'hA5;
        #1;
        chk("R6 write strobes", {14'h0, ee_req, ee_we}, 16'h0003);
        chk("R6 write data", {8'h0, ee_wdata}, 16'h00A5);
        cyc();
        mem_req = 1'b0; mem_we = 1'b0;
        rd(8'h96, d);
        chk("R6 busy flag", {8'h0, d}, 16'h0018);
        mem_req = 1'b1;
        #1;
        chk("R8 read blocked while busy", {15'h0, ee_req}, 16'h0000);
        mem_we = 1'b1;
        #1;
        chk("R8 write blocked while busy", {15'h0, ee_req}, 16'h0000);
        mem_req = 1'b0; mem_we = 1'b0;
        cyc(); cyc();
        rd(8'h96, d);
        chk("R6 still busy before done", {8'h0, d}, 16'h0018);
        ee_done = 1'b1; cyc(); ee_done = 1'b0;
        rd(8'h96, d);
        chk("R6 ready after done", {8'h0, d}, 16'h001A);
    endtask

    task automatic t_kick();
        logic [7:0] d;
        chk("R9 kick idle", {15'h0, wdt_kick}, 16'h0000);
        wr(8'h96, 8'hE3);
        chk("R9 kick pulse", {15'h0, wdt_kick}, 16'h0001);
        rd(8'h96, d);
        chk("R9 bit1 not stored, unused bits zero", {8'h0, d}, 16'h0002);
        cyc();
        chk("R9 kick one cycle", {15'h0, wdt_kick}, 16'h0000);
    endtask

    task automatic t_collide();
        logic [15:0] p;
        wr(8'h96, 8'h04);
        wr(8'h84, 8'h10); wr(8'h85, 8'h00);
        sfr_addr = 8'h84; sfr_wdata = 8'h55; sfr_wr = 1'b1; dptr_inc = 1'b1;
        cyc();
        sfr_wr = 1'b0; dptr_inc = 1'b0;
        rd_ptr(1, p); chk("R10 write wins over increment", p, 16'h0055);
        sfr_addr = 8'h82; sfr_wdata = 8'h77; sfr_wr = 1'b1; dptr_inc = 1'b1;
        cyc();
        sfr_wr = 1'b0; dptr_inc = 1'b0;
        rd_ptr(1, p); chk("R10 increment with other-bank write", p, 16'h0056);
        rd_ptr(0, p); chk("R10 other bank written", p, 16'h1277);
    endtask

    initial begin
        rst = 1'b1; sfr_addr = 8'h00; sfr_wr = 1'b0; sfr_wdata = 8'h00;
        dptr_inc = 1'b0; mem_req = 1'b0; mem_we = 1'b0; mem_wdata = 8'h00;
        ee_rdata = 8'h00; ee_done = 1'b0; xm_rdata = 8'h00;
        @(negedge clk); cyc(); cyc();
        rst = 1'b0;
        t_reset();
        t_ptr_rw();
        t_select_ext();
        t_inc();
        wr(8'h84, 8'hCD); wr(8'h85, 8'hAB);
        t_route_ee();
        t_write_ignored();
        t_ee_write();
        t_kick();
        t_collide();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule